// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Frozen-Pin Output

This block merges many interrupt events into a single interrupt pin through two status levels. Two second-level groups, one with six sources and one with eleven, each keep sticky status bits and per-bit enables. Each group reduces to one summary bit. The six-source group also has a master enable that gates its summary. Each summary sets its own bit in a ten-source first-level status register, which has its own enable register. The enabled first-level bits are OR-reduced into a pin request.

The pin request reaches the output through a latch that a pin-enable bit controls. While pin-enable is low, the pin keeps its last value whatever software writes to the interrupt registers. With this latch, software can silence the pin in two ways. It can clear the pending first-level status, or it can mask the first-level enables while the pending status stays intact. Afterwards it turns the pin back on.

Software reaches the block through a simple single-cycle register port. Status registers are write-one-to-clear, and the other registers are written directly. Reads are combinational on the address. Event inputs are one-cycle pulses.

Top module: `irq_aggregator`

## Requirements
- R1: When reset is released, every status bit, every enable bit, the master enable and pin-enable are 0, `irq_o` is 0, and every register reads as 0.
- R2: Status bits are sticky. An event pulse sets its bit on the next clock edge. Writing 1 to a bit position of a status register clears that bit. An event in the same cycle as a clear of the same bit leaves the bit set.
- R3: The six-source group's summary is the OR of its enabled status bits (address 0 status, address 1 enables in bits 5:0), ANDed with the master enable at bit 31 of address 1. A summary of 1 sets first-level status bit 0 on the next edge.
- R4: The eleven-source group's summary is the OR of its enabled status bits (address 2 status, address 3 enables in bits 10:0), with no master gating. A summary of 1 sets first-level status bit 1 on the next edge.
- R5: First-level status (address 4) and enable (address 5) hold ten bits, and the direct event inputs set them. A bit fed by a group summary that is still 1 cannot be cleared; it is set again in the same edge.
- R6: While pin-enable (address 6, bit 0) is 1, `irq_o` takes the OR of enabled first-level status bits one clock after that OR changes.
- R7: While pin-enable is 0, `irq_o` holds its value whatever register writes or events occur.
- R8: Setting pin-enable to 1, then clearing all first-level status bits, then setting pin-enable to 0, leaves `irq_o` at 0 and frozen.
- R9: Setting pin-enable to 1, then clearing all first-level enables, then setting pin-enable to 0, drives `irq_o` to 0 and keeps the first-level status. Restoring the enables and then setting pin-enable to 1 drives `irq_o` to 1 again.
- R10: Address 7 reads as 0, and writes to it change nothing. Unused bit positions of every register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| evt_a_i | input | 6 | Event pulses, six-source group |
| evt_b_i | input | 11 | Event pulses, eleven-source group |
| evt_top_i | input | 10 | Direct event pulses into first-level status |
| irq_o | output | 1 | Interrupt pin |

## Verification
The bench targets a clear that coincides with a new event on the same bit. A design that gave the clear priority would silently lose that event. It also clears a first-level summary bit while the group status underneath is still pending. A design that allowed this would drop an interrupt that software never serviced. The two pin-silencing procedures are run step by step, and further writes follow while pin-enable is low. A latch wired as a plain enable gate would let the pin move or stick high during these steps, and a design that cleared status on masking would lose the pending work after re-enable. Random traffic then mixes writes, events and pin-enable toggles against a behavioural model on every cycle, so that an off-by-one in the three-edge path from group event to pin shows up as a miscompare.

// File: rtl/irq_agg_pkg.sv
// Package: register map and fixed bit positions shared by the aggregator.
// Assumes a 3-bit address; encodings are the register map software sees.
package irq_agg_pkg;
    typedef enum logic [2:0] {
        REG_A_STAT = 3'd0,
        REG_A_EN   = 3'd1,
        REG_B_STAT = 3'd2,
        REG_B_EN   = 3'd3,
        REG_T_STAT = 3'd4,
        REG_T_EN   = 3'd5,
        REG_CFG    = 3'd6
    } reg_sel_e;

    localparam int PIN_EN_BIT = 0;
endpackage

// File: rtl/irq_group.sv
// irq_group: one bank of sticky status bits with matching enables that
// reduces to a single summary bit. HAS_MASTER selects an extra master
// enable bit that gates the summary.
// Assumes event pulses last one cycle, and that the stat_we_i/en_we_i
// strobes already come decoded from the register port.
module irq_group #(
    parameter int N          = 6,
    parameter bit HAS_MASTER = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         stat_we_i,
    input  logic         en_we_i,
    input  logic [N-1:0] wdata_i,
    input  logic         master_wr_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] en_o,
    output logic         master_o,
    output logic         sum_o
);
    logic [N-1:0] stat_q;
    logic [N-1:0] en_q;
    logic [N-1:0] clr_mask;
    logic         any_enabled;

    // Decode the write-one-to-clear mask for this cycle.
    always_comb clr_mask = stat_we_i ? wdata_i : '0;

    // Sticky status: clear by mask, an event always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | evt_i;
    end

    // Per-bit enable register, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= wdata_i;
    end

    // OR of the enabled status bits.
    always_comb any_enabled = |(stat_q & en_q);

    generate
        if (HAS_MASTER) begin : g_master
            logic master_q;
            // Master enable bit, written with the enable register.
            always_ff @(posedge clk) begin
                if (!rst_n)       master_q <= 1'b0;
                else if (en_we_i) master_q <= master_wr_i;
            end
            assign master_o = master_q;
            assign sum_o    = any_enabled & master_q;
        end else begin : g_plain
            logic unused_master;
            assign unused_master = master_wr_i;
            assign master_o      = 1'b0;
            assign sum_o         = any_enabled;
        end
    endgenerate

    assign stat_o = stat_q;
    assign en_o   = en_q;

    // R2: a set bit that was not cleared stays set.
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~$past(clr_mask) & ~stat_q) == '0));
    // R2: an event pulse always leaves its bit set, even under a clear.
    p_event_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_i) & ~stat_q) == '0));
endmodule

// File: rtl/irq_pin_latch.sv
// irq_pin_latch: holds the pin-enable configuration bit and the output pin
// register. The pin copies the request only on edges where pin-enable is
// already 1, and freezes otherwise.
// Assumes req_i is a registered-state OR with no glitch concerns.
module irq_pin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we_i,
    input  logic pe_wr_i,
    input  logic req_i,
    output logic pe_o,
    output logic irq_o
);
    logic pe_q;
    logic irq_q;

    // Pin-enable configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        pe_q <= 1'b0;
        else if (cfg_we_i) pe_q <= pe_wr_i;
    end

    // Output latch: transparent while pin-enable is 1, frozen otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_q <= 1'b0;
        else if (pe_q) irq_q <= req_i;
    end

    assign pe_o  = pe_q;
    assign irq_o = irq_q;

    // R7: pin is frozen while pin-enable was low.
    p_pin_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pe_q) |-> (irq_q == $past(irq_q)));
    // R6: with pin-enable high the pin tracks the request one cycle later.
    p_pin_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pe_q) |-> (irq_q == $past(req_i)));
endmodule

// File: rtl/irq_aggregator.sv
// irq_aggregator: two second-level groups feed dedicated bits of a
// first-level group, whose enabled OR drives the interrupt pin through a
// latch controlled by pin-enable.
// Assumes a single-cycle write port and combinational reads; event inputs
// are one-cycle pulses in the clk domain.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int A_W        = 6,
    parameter int B_W        = 11,
    parameter int T_W        = 10,
    parameter int DW         = 32,
    parameter int MASTER_BIT = 31,
    parameter int A_SLOT     = 0,
    parameter int B_SLOT     = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [2:0]     addr_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o,
    input  logic [A_W-1:0] evt_a_i,
    input  logic [B_W-1:0] evt_b_i,
    input  logic [T_W-1:0] evt_top_i,
    output logic           irq_o
);
    logic [A_W-1:0] a_stat, a_en;
    logic [B_W-1:0] b_stat, b_en;
    logic [T_W-1:0] t_stat, t_en, t_evt;
    logic           a_master, b_master_unused, t_master_unused;
    logic           a_sum, b_sum, t_sum;
    logic           pin_en;
    logic           we_a_stat, we_a_en, we_b_stat, we_b_en;
    logic           we_t_stat, we_t_en, we_cfg;
    logic           unused_wdata;

    assign unused_wdata = &{1'b0, wdata_i};

    // Decode write strobes from the address.
    always_comb begin
        we_a_stat = wr_en_i && (addr_i == REG_A_STAT);
        we_a_en   = wr_en_i && (addr_i == REG_A_EN);
        we_b_stat = wr_en_i && (addr_i == REG_B_STAT);
        we_b_en   = wr_en_i && (addr_i == REG_B_EN);
        we_t_stat = wr_en_i && (addr_i == REG_T_STAT);
        we_t_en   = wr_en_i && (addr_i == REG_T_EN);
        we_cfg    = wr_en_i && (addr_i == REG_CFG);
    end

    irq_group #(.N(A_W), .HAS_MASTER(1'b1)) u_grp_a (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_a_i),
        .stat_we_i(we_a_stat), .en_we_i(we_a_en),
        .wdata_i(wdata_i[A_W-1:0]), .master_wr_i(wdata_i[MASTER_BIT]),
        .stat_o(a_stat), .en_o(a_en), .master_o(a_master), .sum_o(a_sum)
    );

    irq_group #(.N(B_W), .HAS_MASTER(1'b0)) u_grp_b (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_b_i),
        .stat_we_i(we_b_stat), .en_we_i(we_b_en),
        .wdata_i(wdata_i[B_W-1:0]), .master_wr_i(1'b0),
        .stat_o(b_stat), .en_o(b_en), .master_o(b_master_unused), .sum_o(b_sum)
    );

    // Merge direct events with the group summaries on their slots.
    always_comb begin
        t_evt         = evt_top_i;
        t_evt[A_SLOT] = evt_top_i[A_SLOT] | a_sum;
        t_evt[B_SLOT] = evt_top_i[B_SLOT] | b_sum;
    end

    irq_group #(.N(T_W), .HAS_MASTER(1'b0)) u_grp_top (
        .clk(clk), .rst_n(rst_n), .evt_i(t_evt),
        .stat_we_i(we_t_stat), .en_we_i(we_t_en),
        .wdata_i(wdata_i[T_W-1:0]), .master_wr_i(1'b0),
        .stat_o(t_stat), .en_o(t_en), .master_o(t_master_unused), .sum_o(t_sum)
    );

    irq_pin_latch u_pin (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(we_cfg),
        .pe_wr_i(wdata_i[PIN_EN_BIT]), .req_i(t_sum),
        .pe_o(pin_en), .irq_o(irq_o)
    );

    // Read multiplexer; unused positions and addresses return zero.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_A_STAT: rdata_o[A_W-1:0] = a_stat;
            REG_A_EN: begin
                rdata_o[A_W-1:0]    = a_en;
                rdata_o[MASTER_BIT] = a_master;
            end
            REG_B_STAT: rdata_o[B_W-1:0] = b_stat;
            REG_B_EN:   rdata_o[B_W-1:0] = b_en;
            REG_T_STAT: rdata_o[T_W-1:0] = t_stat;
            REG_T_EN:   rdata_o[T_W-1:0] = t_en;
            REG_CFG:    rdata_o[PIN_EN_BIT] = pin_en;
            default:    rdata_o = '0;
        endcase
    end

    // R3: a gated summary from group A appears in first-level slot A.
    p_grp_a_feeds_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_sum) |-> t_stat[A_SLOT]);
    // R4: group B summary appears in first-level slot B.
    p_grp_b_feeds_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(b_sum) |-> t_stat[B_SLOT]);
    // R1: leaving reset, the pin and first-level status are clear.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && t_stat == '0 && !pin_en));
endmodule

// File: tb/irq_aggregator_tb.sv
// Bench: drives the aggregator from tasks and compares it every clock with a
// behavioural model; directed scenarios first, then random traffic.
module irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [5:0]  evt_a = '0;
    logic [10:0] evt_b = '0;
    logic [9:0]  evt_t = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic [5:0]  m_ast, m_aen;
    logic        m_amst;
    logic [10:0] m_bst, m_ben;
    logic [9:0]  m_tst, m_ten;
    logic        m_pe, m_pin;

    always #2 clk = ~clk;

    irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .evt_a_i(evt_a), .evt_b_i(evt_b),
        .evt_top_i(evt_t), .irq_o(irq)
    );

    function automatic logic [31:0] mread(input logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r[5:0]  = m_ast;
            3'd1: begin r[5:0] = m_aen; r[31] = m_amst; end
            3'd2: r[10:0] = m_bst;
            3'd3: r[10:0] = m_ben;
            3'd4: r[9:0]  = m_tst;
            3'd5: r[9:0]  = m_ten;
            3'd6: r[0]    = m_pe;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_edge();
        logic sa, sb, npin;
        logic [5:0]  ca;
        logic [10:0] cb;
        logic [9:0]  ct;
        if (!rst_n) begin
            m_ast = '0; m_aen = '0; m_amst = 0; m_bst = '0; m_ben = '0;
            m_tst = '0; m_ten = '0; m_pe = 0; m_pin = 0;
        end else begin
            sa   = (|(m_ast & m_aen)) && m_amst;
            sb   = |(m_bst & m_ben);
            npin = m_pe ? |(m_tst & m_ten) : m_pin;
            ca = (wr_en && addr == 3'd0) ? wdata[5:0]  : '0;
            cb = (wr_en && addr == 3'd2) ? wdata[10:0] : '0;
            ct = (wr_en && addr == 3'd4) ? wdata[9:0]  : '0;
            m_ast = (m_ast & ~ca) | evt_a;
            m_bst = (m_bst & ~cb) | evt_b;
            m_tst = (m_tst & ~ct) | evt_t | {8'd0, sb, sa};
            if (wr_en && addr == 3'd1) begin m_aen = wdata[5:0]; m_amst = wdata[31]; end
            if (wr_en && addr == 3'd3) m_ben = wdata[10:0];
            if (wr_en && addr == 3'd5) m_ten = wdata[9:0];
            if (wr_en && addr == 3'd6) m_pe = wdata[0];
            m_pin = npin;
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "irq", {31'd0, irq}, {31'd0, m_pin});
        chk(tag, "rdata", rdata, mread(addr));
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        wr_en = 1'b1; addr = a; wdata = d;
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        tick(tag);
        chk(tag, "direct read", rdata, exp);
    endtask

    task automatic evt(input logic [5:0] ea, input logic [10:0] eb,
                       input logic [9:0] et, input string tag);
        evt_a = ea; evt_b = eb; evt_t = et;
        tick(tag);
        evt_a = '0; evt_b = '0; evt_t = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        repeat (4) tick("R1");
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R1");
        chk("R1", "irq after reset", {31'd0, irq}, 32'd0);

        // R2: sticky set, same-cycle clear loses to event, plain clear
        evt(6'h04, '0, '0, "R2");
        rd(3'd0, 32'h4, "R2");
        evt_a = 6'h04;
        wr(3'd0, 32'h4, "R2");
        evt_a = '0;
        rd(3'd0, 32'h4, "R2");
        wr(3'd0, 32'h4, "R2");
        rd(3'd0, 32'h0, "R2");

        // R3: group A summary only with master enable
        evt(6'h20, '0, '0, "R3");
        wr(3'd1, 32'h0000_0020, "R3");
        tick("R3");
        rd(3'd4, 32'h0, "R3");
        wr(3'd1, 32'h8000_0020, "R3");
        tick("R3");
        rd(3'd4, 32'h1, "R3");
        rd(3'd1, 32'h8000_0020, "R3");

        // R5: summary-fed bit cannot be cleared while the summary is 1
        wr(3'd4, 32'h1, "R5");
        rd(3'd4, 32'h1, "R5");
        wr(3'd0, 32'h20, "R5");
        wr(3'd4, 32'h1, "R5");
        rd(3'd4, 32'h0, "R5");
        evt('0, '0, 10'h200, "R5");
        rd(3'd4, 32'h200, "R5");

        // R4: group B summary, no master gating
        wr(3'd3, 32'h400, "R4");
        evt('0, 11'h400, '0, "R4");
        tick("R4");
        rd(3'd4, 32'h202, "R4");

        // R6: pin follows enabled request
        wr(3'd5, 32'h200, "R6");
        wr(3'd6, 32'h1, "R6");
        tick("R6");
        chk("R6", "irq on", {31'd0, irq}, 32'd1);

        // R8: clear-status procedure leaves the pin low and frozen
        wr(3'd2, 32'h400, "R8");
        wr(3'd4, 32'h3FF, "R8");
        wr(3'd6, 32'h0, "R8");
        chk("R8", "irq low", {31'd0, irq}, 32'd0);
        // R7: frozen against new events and writes
        evt('0, '0, 10'h200, "R7");
        wr(3'd5, 32'h3FF, "R7");
        repeat (3) tick("R7");
        chk("R7", "irq frozen", {31'd0, irq}, 32'd0);

        // R9: mask procedure keeps status, restore re-asserts
        wr(3'd6, 32'h1, "R9");
        tick("R9");
        chk("R9", "irq up", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h0, "R9");
        wr(3'd6, 32'h0, "R9");
        chk("R9", "irq masked", {31'd0, irq}, 32'd0);
        rd(3'd4, 32'h200, "R9");
        wr(3'd5, 32'h200, "R9");
        wr(3'd6, 32'h1, "R9");
        tick("R9");
        chk("R9", "irq restored", {31'd0, irq}, 32'd1);

        // R10: address 7 ignored
        wr(3'd7, 32'hFFFF_FFFF, "R10");
        rd(3'd7, 32'h0, "R10");
        rd(3'd6, 32'h1, "R10");
        rd(3'd5, 32'h200, "R10");

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 3) == 0);
            addr  = 3'($urandom_range(0, 7));
            wdata = $urandom();
            evt_a = ($urandom_range(0, 3) == 0) ? 6'($urandom()) : '0;
            evt_b = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : '0;
            evt_t = ($urandom_range(0, 5) == 0) ? 10'($urandom()) : '0;
            tick("RAND");
        end
        wr_en = 1'b0; evt_a = '0; evt_b = '0; evt_t = '0;
        tick("RAND");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule